// File: doc/BRIEF.md
# Descriptor-Chained 2D Memory Copy Engine

This block is a single-channel copy engine that walks a chain of descriptors held in ordinary memory. Software writes the descriptors, gives the engine the address of the first one and pulses `start`. For each descriptor the engine reads eight 32-bit words through a word-wide read port. It then copies the requested number of bytes from source to destination through the same read port and a word-wide write port. After that it follows the descriptor's link to the next one.

Each descriptor chooses, separately for source and destination, whether the address steps forward or stays fixed. It can also split the copy into lines. Each line is a fixed number of bytes, and the source and destination each skip ahead by their own stride between lines. Two flags in the control word stop the engine after the node until `resume` is pulsed, or raise a one-cycle interrupt pulse when the node finishes. A zero link ends the chain with `done`. A misaligned descriptor address stops the chain with `err`. Transfers are whole 32-bit words, so all byte quantities are taken as multiples of four.

Top module: `dma2d_engine`

## Requirements
- R1: After `start`, the engine reads the eight descriptor words at consecutive word addresses from the descriptor address upward before moving any data. The words are, in order: link, control, byte count, source address, destination address, line length, source stride, destination stride. No memory access happens while `busy` is low.
- R2: A mode field equal to binary 10 selects increment mode. The source field is control bits [6:5] and the destination field is control bits [8:7]. In increment mode the address advances by 4 after every word. Each word read from the source address is written unchanged to the destination address.
- R3: Any other value of a mode field (01, 00 or 11) makes that address static: every word of the node uses the descriptor's address.
- R4: With a nonzero line length, a new line starts after each line-length bytes. The new line's source start is the previous source line start plus the source stride, and the destination start moves the same way by the destination stride. A stride applies only to an address in increment mode.
- R5: When the byte count is not a multiple of the line length, the last line carries only the remaining bytes. A line length of zero makes the whole count a single line.
- R6: Control bit 31 makes `irq` high for exactly one cycle after the node's last write.
- R7: Control bit 30 makes the engine hold `paused` high after the node, with `busy` high and no memory access, until `resume` is pulsed. It then follows the link.
- R8: A link of zero, or a head address of zero, ends the chain. `busy` goes low and `done` goes high and stays high until the next `start`.
- R9: A descriptor address with any of bits [4:0] set raises `err`, drops `busy`, leaves `done` low and performs no fetch or copy for that descriptor.
- R10: Control bits [4:0], the request-source field, have no effect: nodes with values 5 and 31 copy exactly as a node with value 0.
- R11: A byte count of zero writes nothing. Bits [1:0] of the byte count, line length, strides and data addresses are ignored.
- R12: After reset `busy`, `paused`, `done`, `err`, `irq`, `rdEn` and `wrEn` are low, and `start` while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a chain at `headAddr` (used only when idle) |
| headAddr | input | ADDR_W | Address of the first descriptor |
| resume | input | 1 | Leave the paused state and follow the link |
| rdEn | output | 1 | One-cycle read request |
| rdAddr | output | ADDR_W | Byte address of the requested word |
| rdValid | input | 1 | Read data returned for the outstanding request |
| rdData | input | 32 | Returned read word |
| wrEn | output | 1 | Write strobe |
| wrAddr | output | ADDR_W | Byte address of the written word |
| wrData | output | 32 | Written word |
| busy | output | 1 | Chain in progress (includes paused) |
| paused | output | 1 | Stopped after a node with the pause flag |
| done | output | 1 | Chain ended on a zero link |
| err | output | 1 | Chain stopped on a misaligned descriptor |
| irq | output | 1 | One-cycle end-of-node interrupt pulse |

## Verification
The assertions assume the memory returns exactly one `rdValid` for each `rdEn`, some cycles later, and never one that was not asked for. They also assume `resume` matters only while `paused` is high. The bench memory model answers every read after one cycle and sends no spontaneous responses. The bench pulses `resume` only after it has seen `paused`. Descriptors, source data and destination areas are placed in separate regions of the model, so no copy overwrites a descriptor that is still to be fetched.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int WORD_BITS  = 32;
  localparam int DESC_WORDS = 8;
  localparam int IDX_W      = $clog2(DESC_WORDS);

  // control word bit positions
  localparam int CTL_SRC_LO = 5;
  localparam int CTL_SRC_HI = 6;
  localparam int CTL_DST_LO = 7;
  localparam int CTL_DST_HI = 8;
  localparam int CTL_PAUSE  = 30;
  localparam int CTL_IRQ    = 31;

  // descriptor word slots
  localparam int SLOT_LINK  = 0;
  localparam int SLOT_CTRL  = 1;
  localparam int SLOT_COUNT = 2;
  localparam int SLOT_SRC   = 3;
  localparam int SLOT_DST   = 4;
  localparam int SLOT_LINE  = 5;
  localparam int SLOT_SSTR  = 6;
  localparam int SLOT_DSTR  = 7;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_FETCH_RD,
    ST_FETCH_WAIT,
    ST_INIT,
    ST_MOVE_CHK,
    ST_MOVE_RD,
    ST_MOVE_WAIT,
    ST_NODE_END,
    ST_PAUSED
  } dmaState_e;

  typedef struct packed {
    logic loadHead;
    logic loadNext;
    logic clrIdx;
    logic storeWord;
    logic initMove;
    logic advWord;
    logic selFetch;
  } dpStrobe_t;

  typedef struct packed {
    logic nodeZero;
    logic nodeMisaligned;
    logic lastWord;
    logic moveDone;
    logic pauseFlag;
    logic irqFlag;
  } dpStatus_t;
endpackage

// File: rtl/dma2d_dpath.sv
module dma2d_dpath
  import dma2d_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobe_t            stb,
  input  logic [ADDR_W-1:0]    headAddr,
  input  logic [WORD_BITS-1:0] rdData,
  output dpStatus_t            status,
  output logic [ADDR_W-1:0]    rdAddr,
  output logic [ADDR_W-1:0]    wrAddr
);
  localparam int ALIGN_LSB = $clog2(ALIGN_BYTES);
  localparam int STEP      = WORD_BITS / 8;

  logic [WORD_BITS-1:0] descWord [DESC_WORDS];
  logic [IDX_W-1:0]     idx;
  logic [ADDR_W-1:0]    nodeAddr;
  logic [ADDR_W-1:0]    srcAddr, dstAddr, srcLine, dstLine;
  logic [WORD_BITS-1:0] bytesLeft, lineLeft;

  // descriptor capture, one register per slot
  for (genvar w = 0; w < DESC_WORDS; w++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) descWord[w] <= '0;
      else if (stb.storeWord && idx == IDX_W'(w)) descWord[w] <= rdData;
    end
  end

  logic [WORD_BITS-1:0] wCtrl, byteCnt, lineLen, sStride, dStride;
  logic [ADDR_W-1:0]    srcBase, dstBase;
  logic                 srcIncr, dstIncr;

  assign wCtrl   = descWord[SLOT_CTRL];
  assign byteCnt = {descWord[SLOT_COUNT][WORD_BITS-1:2], 2'b00};
  assign lineLen = {descWord[SLOT_LINE][WORD_BITS-1:2], 2'b00};
  assign sStride = {descWord[SLOT_SSTR][WORD_BITS-1:2], 2'b00};
  assign dStride = {descWord[SLOT_DSTR][WORD_BITS-1:2], 2'b00};
  assign srcBase = {descWord[SLOT_SRC][ADDR_W-1:2], 2'b00};
  assign dstBase = {descWord[SLOT_DST][ADDR_W-1:2], 2'b00};
  assign srcIncr = wCtrl[CTL_SRC_HI] & ~wCtrl[CTL_SRC_LO];
  assign dstIncr = wCtrl[CTL_DST_HI] & ~wCtrl[CTL_DST_LO];

  logic unusedBits;
  assign unusedBits = ^{wCtrl[CTL_SRC_LO-1:0], wCtrl[CTL_PAUSE-1:CTL_DST_HI+1],
                        descWord[SLOT_COUNT][1:0], descWord[SLOT_LINE][1:0],
                        descWord[SLOT_SSTR][1:0], descWord[SLOT_DSTR][1:0],
                        descWord[SLOT_SRC][1:0], descWord[SLOT_DST][1:0]};

  logic [ADDR_W-1:0] srcNextLine, dstNextLine, srcStep, dstStep;
  assign srcNextLine = srcLine + (srcIncr ? sStride[ADDR_W-1:0] : '0);
  assign dstNextLine = dstLine + (dstIncr ? dStride[ADDR_W-1:0] : '0);
  assign srcStep     = srcIncr ? ADDR_W'(STEP) : '0;
  assign dstStep     = dstIncr ? ADDR_W'(STEP) : '0;

  // fetch index and current descriptor address
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx      <= '0;
      nodeAddr <= '0;
    end else begin
      if (stb.clrIdx) idx <= '0;
      else if (stb.storeWord) idx <= idx + 1'b1;
      if (stb.loadHead) nodeAddr <= headAddr;
      else if (stb.loadNext) nodeAddr <= descWord[SLOT_LINK][ADDR_W-1:0];
    end
  end

  // address generation and byte accounting
  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr   <= '0;
      dstAddr   <= '0;
      srcLine   <= '0;
      dstLine   <= '0;
      bytesLeft <= '0;
      lineLeft  <= '0;
    end else if (stb.initMove) begin
      srcAddr   <= srcBase;
      srcLine   <= srcBase;
      dstAddr   <= dstBase;
      dstLine   <= dstBase;
      bytesLeft <= byteCnt;
      lineLeft  <= (lineLen == '0) ? byteCnt : lineLen;
    end else if (stb.advWord) begin
      bytesLeft <= bytesLeft - WORD_BITS'(STEP);
      if (lineLeft == WORD_BITS'(STEP)) begin
        srcLine  <= srcNextLine;
        srcAddr  <= srcNextLine;
        dstLine  <= dstNextLine;
        dstAddr  <= dstNextLine;
        lineLeft <= lineLen;
      end else begin
        lineLeft <= lineLeft - WORD_BITS'(STEP);
        srcAddr  <= srcAddr + srcStep;
        dstAddr  <= dstAddr + dstStep;
      end
    end
  end

  assign rdAddr = stb.selFetch ? nodeAddr + (ADDR_W'(idx) << 2) : srcAddr;
  assign wrAddr = dstAddr;

  assign status.nodeZero       = (nodeAddr == '0);
  assign status.nodeMisaligned = |nodeAddr[ALIGN_LSB-1:0];
  assign status.lastWord       = (idx == IDX_W'(DESC_WORDS - 1));
  assign status.moveDone       = (bytesLeft == '0);
  assign status.pauseFlag      = wCtrl[CTL_PAUSE];
  assign status.irqFlag        = wCtrl[CTL_IRQ];
endmodule

// File: rtl/dma2d_ctrl.sv
module dma2d_ctrl
  import dma2d_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      resume,
  input  logic      rdValid,
  input  dpStatus_t status,
  output dpStrobe_t stb,
  output logic      rdEn,
  output logic      wrEn,
  output logic      busy,
  output logic      paused,
  output logic      done,
  output logic      err,
  output logic      irq
);
  dmaState_e state, stateNext;
  logic      doneSet, errSet;

  always_comb begin
    stateNext = state;
    stb       = '0;
    rdEn      = 1'b0;
    wrEn      = 1'b0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          stb.loadHead = 1'b1;
          stateNext    = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (status.nodeZero) begin
          doneSet   = 1'b1;
          stateNext = ST_IDLE;
        end else if (status.nodeMisaligned) begin
          errSet    = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          stb.clrIdx = 1'b1;
          stateNext  = ST_FETCH_RD;
        end
      end
      ST_FETCH_RD: begin
        stb.selFetch = 1'b1;
        rdEn         = 1'b1;
        stateNext    = ST_FETCH_WAIT;
      end
      ST_FETCH_WAIT: begin
        if (rdValid) begin
          stb.storeWord = 1'b1;
          stateNext     = status.lastWord ? ST_INIT : ST_FETCH_RD;
        end
      end
      ST_INIT: begin
        stb.initMove = 1'b1;
        stateNext    = ST_MOVE_CHK;
      end
      ST_MOVE_CHK: stateNext = status.moveDone ? ST_NODE_END : ST_MOVE_RD;
      ST_MOVE_RD: begin
        rdEn      = 1'b1;
        stateNext = ST_MOVE_WAIT;
      end
      ST_MOVE_WAIT: begin
        if (rdValid) begin
          wrEn        = 1'b1;
          stb.advWord = 1'b1;
          stateNext   = ST_MOVE_CHK;
        end
      end
      ST_NODE_END: begin
        stb.loadNext = 1'b1;
        stateNext    = status.pauseFlag ? ST_PAUSED : ST_CHECK;
      end
      ST_PAUSED: if (resume) stateNext = ST_CHECK;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      err   <= 1'b0;
      irq   <= 1'b0;
    end else begin
      state <= stateNext;
      irq   <= (state == ST_NODE_END) && status.irqFlag;
      if (stb.loadHead) done <= 1'b0;
      else if (doneSet) done <= 1'b1;
      if (stb.loadHead) err <= 1'b0;
      else if (errSet) err <= 1'b1;
    end
  end

  assign busy   = (state != ST_IDLE);
  assign paused = (state == ST_PAUSED);
endmodule

// File: rtl/dma2d_engine.sv
module dma2d_engine
  import dma2d_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ALIGN_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [ADDR_W-1:0]    headAddr,
  input  logic                 resume,
  output logic                 rdEn,
  output logic [ADDR_W-1:0]    rdAddr,
  input  logic                 rdValid,
  input  logic [WORD_BITS-1:0] rdData,
  output logic                 wrEn,
  output logic [ADDR_W-1:0]    wrAddr,
  output logic [WORD_BITS-1:0] wrData,
  output logic                 busy,
  output logic                 paused,
  output logic                 done,
  output logic                 err,
  output logic                 irq
);
  dpStrobe_t stb;
  dpStatus_t status;

  dma2d_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .resume (resume),
    .rdValid(rdValid),
    .status (status),
    .stb    (stb),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .busy   (busy),
    .paused (paused),
    .done   (done),
    .err    (err),
    .irq    (irq)
  );

  dma2d_dpath #(
    .ADDR_W     (ADDR_W),
    .ALIGN_BYTES(ALIGN_BYTES)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .headAddr(headAddr),
    .rdData  (rdData),
    .status  (status),
    .rdAddr  (rdAddr),
    .wrAddr  (wrAddr)
  );

  assign wrData = rdData;
endmodule

// File: rtl/dma2d_sva.sv
module dma2d_sva #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              wrEn,
  input logic              busy,
  input logic              paused,
  input logic              done,
  input logic              err,
  input logic              irq
);
  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!rdEn && !wrEn));

  a_r2_word_reads: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (rdAddr[1:0] == 2'b00));

  a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);

  a_r7_pause_no_access: assert property (@(posedge clk) disable iff (!rstN)
    paused |-> (busy && !rdEn && !wrEn));

  a_r8_done_means_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  a_r9_err_excludes_done: assert property (@(posedge clk) disable iff (!rstN)
    err |-> (!done && !busy));

  a_r12_start_clears_flags: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (busy && !done && !err));

  a_r12_no_read_write_overlap: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rdEn, wrEn}) <= 1);
endmodule

bind dma2d_engine dma2d_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .rdEn  (rdEn),
  .rdAddr(rdAddr),
  .wrEn  (wrEn),
  .busy  (busy),
  .paused(paused),
  .done  (done),
  .err   (err),
  .irq   (irq)
);

// File: tb/dma2d_engine_tb.sv
module dma2d_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [31:0] headAddr = '0;
  logic        resume = 1'b0;
  logic        rdEn, wrEn, busy, paused, done, err, irq;
  logic [31:0] rdAddr, wrAddr, wrData;
  logic        rdValid = 1'b0;
  logic [31:0] rdData = '0;

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [0:2047];
  logic        tbWe = 1'b0;
  logic [31:0] tbA = '0, tbD = '0;

  always #4 clk = ~clk;

  dma2d_engine dut_i (
    .clk(clk), .rstN(rstN), .start(start), .headAddr(headAddr), .resume(resume),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdValid(rdValid), .rdData(rdData),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .busy(busy), .paused(paused), .done(done), .err(err), .irq(irq)
  );

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    rdValid <= rstN && rdEn;
    if (rdEn) rdData <= mem[rdAddr[12:2]];
    if (wrEn) mem[wrAddr[12:2]] <= wrData;
    if (tbWe) mem[tbA[12:2]] <= tbD;
  end

  localparam logic [31:0] SRC = 32'h1000;
  localparam logic [31:0] DST = 32'h1800;
  localparam logic [31:0] INC2 = 32'h0000_0140; // src and dst increment

  function automatic logic [31:0] srcWord(input int i);
    return 32'hA500_0000 + i;
  endfunction

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem[a[12:2]];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic poke(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tbWe = 1'b1; tbA = a; tbD = d;
  endtask

  task automatic pokeEnd();
    @(negedge clk);
    tbWe = 1'b0;
  endtask

  task automatic writeNode(input logic [31:0] at, link, ctl, cnt, sa, da, len, ss, ds);
    poke(at, link); poke(at + 4, ctl); poke(at + 8, cnt); poke(at + 12, sa);
    poke(at + 16, da); poke(at + 20, len); poke(at + 24, ss); poke(at + 28, ds);
    pokeEnd();
  endtask

  task automatic clearDst();
    for (int i = 0; i < 96; i++) poke(DST + 4 * i, 32'h0);
    pokeEnd();
  endtask

  task automatic waitIdle(output int irqs);
    bit finished = 1'b0;
    irqs = 0;
    for (int c = 0; c < 3000; c++) begin
      if (irq) irqs++;
      if (!busy || paused) begin finished = 1'b1; break; end
      @(negedge clk);
    end
    check(finished, "R8", "chain did not settle", 32'h0, 32'h1);
  endtask

  task automatic runChain(input logic [31:0] head, output int irqs);
    @(negedge clk);
    start = 1'b1; headAddr = head;
    @(negedge clk);
    start = 1'b0;
    waitIdle(irqs);
  endtask

  task automatic testReset();
    check(!busy && !paused && !done && !err && !irq && !rdEn && !wrEn, "R12",
          "reset outputs", {25'b0, busy, paused, done, err, irq, rdEn, wrEn}, 32'h0);
  endtask

  task automatic testLinear();
    int n;
    clearDst();
    writeNode(32'h100, 32'h120, INC2, 32'd16, SRC, DST, 0, 0, 0);
    writeNode(32'h120, 32'h0, INC2, 32'd8, SRC + 32'h40, DST + 32'h40, 0, 0, 0);
    runChain(32'h100, n);
    for (int i = 0; i < 4; i++)
      check(peek(DST + 4 * i) == srcWord(i), "R2", "linear node A", peek(DST + 4 * i), srcWord(i));
    check(peek(DST + 16) == 0, "R1", "byte count honoured", peek(DST + 16), 0);
    check(peek(DST + 32'h40) == srcWord(16) && peek(DST + 32'h44) == srcWord(17), "R1",
          "linked node B", peek(DST + 32'h44), srcWord(17));
    check(done && !busy && !err, "R8", "done after zero link", {29'b0, done, busy, err}, 32'h4);
  endtask

  task automatic testStatic();
    int n;
    clearDst();
    // source static (01), destination increment
    writeNode(32'h100, 32'h120, 32'h0000_0120, 32'd12, SRC + 8, DST, 0, 0, 0);
    // source increment, destination static (01)
    writeNode(32'h120, 32'h140, 32'h0000_00C0, 32'd12, SRC, DST + 32'h100, 0, 0, 0);
    // source field 00 (static), destination increment
    writeNode(32'h140, 32'h0, 32'h0000_0100, 32'd8, SRC + 12, DST + 32'h80, 0, 0, 0);
    runChain(32'h100, n);
    for (int i = 0; i < 3; i++)
      check(peek(DST + 4 * i) == srcWord(2), "R3", "static source", peek(DST + 4 * i), srcWord(2));
    check(peek(DST + 32'h100) == srcWord(2), "R3", "static dest holds last", peek(DST + 32'h100), srcWord(2));
    check(peek(DST + 32'h104) == 0, "R3", "static dest no step", peek(DST + 32'h104), 0);
    check(peek(DST + 32'h84) == srcWord(3), "R3", "mode 00 is static", peek(DST + 32'h84), srcWord(3));
  endtask

  task automatic test2d();
    int n;
    logic [31:0] expv [8];
    clearDst();
    writeNode(32'h100, 32'h0, INC2, 32'd24, SRC, DST, 32'd8, 32'd16, 32'd12);
    runChain(32'h100, n);
    expv = '{srcWord(0), srcWord(1), 0, srcWord(4), srcWord(5), 0, srcWord(8), srcWord(9)};
    for (int i = 0; i < 8; i++)
      check(peek(DST + 4 * i) == expv[i], "R4", "2D line layout", peek(DST + 4 * i), expv[i]);
  endtask

  task automatic testPartial();
    int n;
    logic [31:0] expv [6];
    clearDst();
    // count 20 with 8-byte lines: 8 + 8 + 4; low bits of count/len/stride ignored
    writeNode(32'h100, 32'h0, INC2, 32'd22, SRC, DST, 32'd9, 32'd17, 32'd10);
    runChain(32'h100, n);
    expv = '{srcWord(0), srcWord(1), srcWord(4), srcWord(5), srcWord(8), 0};
    for (int i = 0; i < 6; i++)
      check(peek(DST + 4 * i) == expv[i], "R5", "partial last line", peek(DST + 4 * i), expv[i]);
  endtask

  task automatic testIrq();
    int n;
    clearDst();
    writeNode(32'h100, 32'h120, 32'h8000_0140, 4, SRC, DST, 0, 0, 0);
    writeNode(32'h120, 32'h140, INC2, 4, SRC + 4, DST + 4, 0, 0, 0);
    writeNode(32'h140, 32'h0, 32'h8000_0140, 4, SRC + 8, DST + 8, 0, 0, 0);
    runChain(32'h100, n);
    check(n == 2, "R6", "irq pulse count", n, 2);
    check(peek(DST + 8) == srcWord(2), "R6", "chain completes", peek(DST + 8), srcWord(2));
  endtask

  task automatic testPause();
    int n;
    clearDst();
    writeNode(32'h100, 32'h120, 32'h4000_0140, 4, SRC, DST, 0, 0, 0);
    writeNode(32'h120, 32'h0, INC2, 4, SRC + 4, DST + 4, 0, 0, 0);
    runChain(32'h100, n);
    check(paused && busy && !done, "R7", "paused after node", {30'b0, paused, busy}, 32'h3);
    repeat (10) @(negedge clk);
    check(paused, "R7", "stays paused", {31'b0, paused}, 1);
    check(peek(DST) == srcWord(0) && peek(DST + 4) == 0, "R7", "next node held back",
          peek(DST + 4), 0);
    resume = 1'b1;
    @(negedge clk);
    resume = 1'b0;
    waitIdle(n);
    check(done && peek(DST + 4) == srcWord(1), "R7", "resume follows link", peek(DST + 4), srcWord(1));
  endtask

  task automatic testZeroHead();
    int n;
    runChain(32'h0, n);
    check(done && !busy && !err, "R8", "zero head ends at once", {29'b0, done, busy, err}, 32'h4);
  endtask

  task automatic testMisaligned();
    int n;
    clearDst();
    writeNode(32'h100, 32'h134, INC2, 4, SRC, DST, 0, 0, 0);
    writeNode(32'h134, 32'h0, INC2, 4, SRC + 4, DST + 4, 0, 0, 0);
    runChain(32'h100, n);
    check(err && !done && !busy, "R9", "misaligned link", {29'b0, err, done, busy}, 32'h4);
    check(peek(DST) == srcWord(0) && peek(DST + 4) == 0, "R9", "no copy at bad node",
          peek(DST + 4), 0);
    clearDst();
    writeNode(32'h140, 32'h0, INC2, 4, SRC, DST, 0, 0, 0);
    runChain(32'h148, n);
    check(err && peek(DST) == 0, "R9", "misaligned head", peek(DST), 0);
  endtask

  task automatic testReqField();
    int n;
    clearDst();
    writeNode(32'h100, 32'h120, 32'h0000_0145, 8, SRC, DST, 0, 0, 0);
    writeNode(32'h120, 32'h0, 32'h0000_015F, 8, SRC + 8, DST + 8, 0, 0, 0);
    runChain(32'h100, n);
    for (int i = 0; i < 4; i++)
      check(peek(DST + 4 * i) == srcWord(i), "R10", "request field ignored", peek(DST + 4 * i), srcWord(i));
  endtask

  task automatic testZeroCount();
    int n;
    clearDst();
    writeNode(32'h100, 32'h0, INC2, 32'd3, SRC, DST, 0, 0, 0);
    runChain(32'h100, n);
    check(done && peek(DST) == 0, "R11", "zero count writes nothing", peek(DST), 0);
  endtask

  task automatic testStartWhileBusy();
    int n;
    clearDst();
    writeNode(32'h100, 32'h0, INC2, 32'd8, SRC, DST, 0, 0, 0);
    writeNode(32'h120, 32'h0, INC2, 32'd8, SRC + 32'h20, DST + 32'h20, 0, 0, 0);
    @(negedge clk);
    start = 1'b1; headAddr = 32'h100;
    @(negedge clk);
    headAddr = 32'h120;
    @(negedge clk);
    start = 1'b0;
    waitIdle(n);
    check(peek(DST + 4) == srcWord(1) && peek(DST + 32'h20) == 0, "R12",
          "start ignored while busy", peek(DST + 32'h20), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) poke(SRC + 4 * i, srcWord(i));
    pokeEnd();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testStatic();
    test2d();
    testPartial();
    testIrq();
    testPause();
    testZeroHead();
    testMisaligned();
    testReqField();
    testZeroCount();
    testStartWhileBusy();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule